// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a 32-bit, read-only, memory-mapped port fetch data from serial flash. It keeps one line of consecutive words plus the address the line was filled from. A read that lands inside the line is answered in the same cycle from that buffer. A read outside the line starts a refill. The engine drives the chip select of the addressed device low and sends a command header. It then exchanges zero bytes to fetch a full line, releases the select, and answers the stalled read.

Bytes are exchanged over a byte-wide request/acknowledge interface. The engine holds `xfer_req` high with the outgoing byte on `xfer_tx`. A byte is exchanged in every cycle where `xfer_ack` is high at the clock edge, and the returned byte is on `xfer_rx` in that same cycle. The serial shifter that sits on that interface is outside this block.

The address is 24 bits within a device. The bits above those 24 select the device, and each device has a 16 MB window. The configuration word holds the command opcode, the mode byte, a mode enable and the dummy count. It must stay stable while a refill runs. A typical value is 0x03A002EB. That value gives opcode 0xEB, mode byte 0xA0 with mode enabled, and two dummy bytes.

Top module: `xip_flash_reader`

## Requirements
- R1: After reset every chip select is high (`cs_n` all ones), `xfer_req` and `rd_ready` are low, and the buffered line is invalid, so the first read always refills.
- R2: On a miss, the chip select of device `rd_addr[AW-1:24]` goes low one cycle after the read is presented. It stays low through every exchange of the refill, and all other selects stay high.
- R3: The header is sent in this order. First the opcode `cfg[7:0]`, then flash address bits 23:16, 15:8 and 7:0. Next comes the mode byte `cfg[23:16]`, but only when `cfg[25]` is 1. Last come `cfg[10:8]` zero bytes.
- R4: Bytes received during the header are discarded. The data phase sends only 0x00 and takes exactly 4*LINE_WORDS exchanges.
- R5: Received data bytes are packed least significant first. Data byte 4k+j of a refill lands in bits 8j+7:8j of word k.
- R6: `rd_ready` stays low during a refill. It rises one cycle after the last data exchange, with word 0 of the new line, which is the word at the requested address.
- R7: When a refill completes, all selects return high and the buffered base becomes the requested address. The base is not aligned to the line.
- R8: A read at an address A with base <= A <= base + 4*LINE_WORDS - 4 is a hit. It returns word (A - base)/4 with `rd_ready` high in the same cycle and causes no exchange.
- R9: A read below the base, or above base + 4*LINE_WORDS - 4, is a miss and refills. This holds even when the low 24 bits match a line held for another device.
- R10: Only whole, word-aligned 32-bit reads are accepted, so `rd_addr[1:0]` is 00 whenever `rd_valid` is high.
- R11: At most one chip select is low at a time, and `xfer_req` is only high while a select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 32 | Header configuration: opcode [7:0], dummy count [10:8], mode byte [23:16], mode enable [25] |
| rd_valid | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | AW (25) | Byte address; bits above 23 select the device |
| rd_ready | output | 1 | Read answered this cycle |
| rd_data | output | 32 | Read data, valid with `rd_ready` |
| cs_n | output | NUM_DEV (2) | Active-low chip selects, one per device |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Byte exchanged at this clock edge |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |

## Verification
A hit is due in the very cycle the read is presented, so the bench samples one time unit after driving and expects zero wait cycles. A miss with header length H needs H + 4*LINE_WORDS exchanges. The flash model acknowledges every cycle, so `rd_ready` is due exactly H + 4*LINE_WORDS + 1 falling edges after the request. The bench counts those edges and compares the count. The model records each header byte, the chip select seen at each exchange, and any nonzero data-phase byte, and these records are checked after the read returns.

// File: rtl/xip_flash_reader.sv
module xip_flash_reader #(
  parameter int LINE_WORDS = 8,
  parameter int NUM_DEV    = 2,
  localparam int AW        = 24 + $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        cfg,
  input  logic               rd_valid,
  input  logic [AW-1:0]      rd_addr,
  output logic               rd_ready,
  output logic [31:0]        rd_data,
  output logic [NUM_DEV-1:0] cs_n,
  output logic               xfer_req,
  output logic [7:0]         xfer_tx,
  input  logic               xfer_ack,
  input  logic [7:0]         xfer_rx
);
  localparam int LINE_BYTES = LINE_WORDS * 4;
  localparam int BW = $clog2(LINE_BYTES);
  localparam int IW = $clog2(LINE_WORDS);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA} st_t;

  st_t             st;
  logic [AW-1:0]   base_q, req_q;
  logic            valid_q;
  logic [3:0]      hcnt;
  logic [BW-1:0]   bcnt;
  logic [31:0]     line_q [LINE_WORDS];

  logic [AW:0]     off;
  logic            hit;
  logic [3:0]      hdr_len;
  logic            unused_cfg;

  assign unused_cfg = ^{cfg[31:26], cfg[24], cfg[15:11]};
  assign off      = {1'b0, rd_addr} - {1'b0, base_q};
  assign hit      = valid_q && !off[AW] && (off[AW-1:0] <= AW'(LINE_BYTES - 4));
  assign rd_ready = rd_valid && hit && (st == S_IDLE);
  assign rd_data  = line_q[off[IW+1:2]];
  assign hdr_len  = 4'd4 + 4'(cfg[25]) + 4'(cfg[10:8]);
  assign xfer_req = (st != S_IDLE);

  always_comb begin
    xfer_tx = 8'h00;
    if (st == S_HDR) begin
      case (hcnt)
        4'd0:    xfer_tx = cfg[7:0];
        4'd1:    xfer_tx = req_q[23:16];
        4'd2:    xfer_tx = req_q[15:8];
        4'd3:    xfer_tx = req_q[7:0];
        4'd4:    xfer_tx = cfg[25] ? cfg[23:16] : 8'h00;
        default: xfer_tx = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      req_q   <= '0;
      valid_q <= 1'b0;
      hcnt    <= '0;
      bcnt    <= '0;
      cs_n    <= '1;
    end else begin
      case (st)
        S_IDLE: if (rd_valid && !hit) begin
          req_q   <= rd_addr;
          valid_q <= 1'b0;
          cs_n    <= ~(NUM_DEV'(1) << rd_addr[AW-1:24]);
          hcnt    <= '0;
          st      <= S_HDR;
        end
        S_HDR: if (xfer_ack) begin
          if (hcnt == hdr_len - 4'd1) begin
            bcnt <= '0;
            st   <= S_DATA;
          end else begin
            hcnt <= hcnt + 4'd1;
          end
        end
        S_DATA: if (xfer_ack) begin
          if (&bcnt) begin
            st      <= S_IDLE;
            cs_n    <= '1;
            base_q  <= req_q;
            valid_q <= 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_DATA && xfer_ack)
      line_q[bcnt[BW-1:2]][8*bcnt[1:0] +: 8] <= xfer_rx;
  end

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> !rd_ready);
  p_one_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);
  p_req_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !(&cs_n));
  p_cs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(cs_n));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && xfer_ack && &bcnt) |=> (&cs_n && valid_q && base_q == $past(req_q)));
  p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[1:0] == 2'b00));
  p_hit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !xfer_req);
endmodule

// File: tb/xip_flash_reader_tb_top.sv
module xip_flash_reader_tb_top;
  localparam int LW = 8;
  localparam int LB = LW * 4;
  localparam logic [31:0] CFG_DEF = 32'h03A0_02EB;

  logic        clk = 0, rst_n = 0;
  logic [31:0] cfg = CFG_DEF;
  logic        rd_valid = 0;
  logic [24:0] rd_addr = '0;
  logic        rd_ready;
  logic [31:0] rd_data;
  logic [1:0]  cs_n;
  logic        xfer_req, xfer_ack = 0;
  logic [7:0]  xfer_tx, xfer_rx = 0;

  int n_vec = 0, n_bad = 0;
  int mcnt = 0, xchg = 0, cs_bad = 0, tx_bad = 0;
  logic last_req = 0;
  logic [24:0] cur_addr = '0;
  logic [7:0] hdr_seen [16];

  always #10 clk = ~clk;

  xip_flash_reader #(.LINE_WORDS(LW), .NUM_DEV(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .cs_n(cs_n), .xfer_req(xfer_req),
    .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx));

  function automatic logic [7:0] fbyte(input logic dev, input logic [23:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ a[23:16] ^ (dev ? 8'hA5 : 8'h00);
  endfunction

  function automatic logic [31:0] expw(input logic [24:0] a);
    return {fbyte(a[24], a[23:0] + 24'd3), fbyte(a[24], a[23:0] + 24'd2),
            fbyte(a[24], a[23:0] + 24'd1), fbyte(a[24], a[23:0])};
  endfunction

  function automatic int hlen();
    return 4 + int'(cfg[25]) + int'(cfg[10:8]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flash model: acknowledges every requested byte
  initial forever begin
    @(negedge clk);
    if (xfer_req) begin
      if (!last_req) mcnt = 0;
      if (mcnt < 16) hdr_seen[mcnt] = xfer_tx;
      if (cs_n !== ~(2'b01 << cur_addr[24])) cs_bad++;
      if (mcnt >= hlen() && xfer_tx !== 8'h00) tx_bad++;
      xfer_ack = 1;
      xfer_rx = (mcnt < hlen()) ? 8'hFF : fbyte(cur_addr[24], cur_addr[23:0] + 24'(mcnt - hlen()));
      mcnt++;
      xchg++;
    end else begin
      xfer_ack = 0;
    end
    last_req = xfer_req;
  end

  task automatic do_read(input logic [24:0] a, input bit miss, input string req);
    int waits, x0, cb0, tb0;
    @(negedge clk);
    cur_addr = a; rd_addr = a; rd_valid = 1;
    x0 = xchg; cb0 = cs_bad; tb0 = tx_bad; waits = 0;
    #1;
    while (!rd_ready && waits < 5000) begin
      @(negedge clk); #1; waits++;
    end
    chk(rd_data === expw(a), {req, " data (R5)"}, rd_data, expw(a));
    chk(waits == (miss ? hlen() + LB + 1 : 0), {req, " latency (R6/R8)"}, waits, miss ? hlen() + LB + 1 : 0);
    chk(xchg - x0 == (miss ? hlen() + LB : 0), {req, " exchanges (R4/R9)"}, xchg - x0, miss ? hlen() + LB : 0);
    chk(cs_n === 2'b11, {req, " cs released (R7)"}, cs_n, 2'b11);
    chk(cs_bad == cb0 && tx_bad == tb0, {req, " cs held / zero data tx (R2/R4)"}, cs_bad - cb0 + tx_bad - tb0, 0);
    rd_valid = 0;
  endtask

  // {miss, address}
  localparam logic [25:0] VEC [10] = '{
    {1'b1, 25'h0000100},  // R1 first read misses
    {1'b0, 25'h0000104},  // R8 hit
    {1'b0, 25'h000011C},  // R8 last word of line
    {1'b1, 25'h0000120},  // R9 just past line
    {1'b1, 25'h000011C},  // R9 just below base
    {1'b0, 25'h0000138},  // R8 upper boundary of new line
    {1'b1, 25'h1000200},  // R2 device 1
    {1'b0, 25'h1000210},  // R8 hit on device 1
    {1'b1, 25'h0000200},  // R9 same low bits, other device
    {1'b0, 25'h0000204}   // R8
  };

  task automatic hdr_chk(input logic [7:0] e [], input string req);
    for (int i = 0; i < e.size(); i++)
      chk(hdr_seen[i] === e[i], req, hdr_seen[i], e[i]);
  endtask

  initial begin
    logic [7:0] e0 [] , e1 [], e2 [];
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n === 2'b11 && !xfer_req && !rd_ready, "R1 reset state", {cs_n, xfer_req, rd_ready}, 4'b1100);
    rst_n = 1;

    foreach (VEC[i]) do_read(VEC[i][24:0], VEC[i][25], $sformatf("vec%0d", i));

    // R3: default header with mode byte and two dummies
    do_read(25'h00ABCD0, 1'b1, "R3 default cfg");
    e0 = '{8'hEB, 8'h0A, 8'hBC, 8'hD0, 8'hA0, 8'h00, 8'h00};
    hdr_chk(e0, "R3 header default");

    // R3: mode disabled, one dummy
    cfg = 32'h0000_010B;
    do_read(25'h1012340, 1'b1, "R3 no mode");
    e1 = '{8'h0B, 8'h01, 8'h23, 8'h40, 8'h00};
    hdr_chk(e1, "R3 header no mode");

    // R3: mode enabled, no dummies
    cfg = 32'h0255_0003;
    do_read(25'h0070008, 1'b1, "R3 mode no dummy");
    e2 = '{8'h03, 8'h07, 8'h00, 8'h08, 8'h55};
    hdr_chk(e2, "R3 header mode only");
    do_read(25'h0070024, 1'b0, "R8 hit after cfg change");

    // R1: reset drops the cached line
    @(negedge clk); rst_n = 0;
    @(negedge clk); #1;
    chk(cs_n === 2'b11 && !xfer_req, "R1 reset again", {cs_n, xfer_req}, 3'b110);
    rst_n = 1;
    do_read(25'h0070024, 1'b1, "R1 miss after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule